// File: doc/BRIEF.md
# Dual-Select RAM/ROM Memory Model

This block is a clock-sampled, synthesizable model of a memory part with two regions. One region is a read/write array and the other is a read-only array. Both regions sit behind one 18-bit address bus and one 8-bit data bus. Each region has its own active-low select. An active-low write strobe and an active-low output strobe complete the control set. On every rising clock edge the block samples all inputs and decodes them into one of these modes: standby, RAM read, RAM write, ROM read, output off, or select conflict. It then updates its registered outputs.

The bidirectional bus is split into `wr_data` (into the part), plus `rd_data` and `rd_drive` (out of the part), so no tri-state logic is needed. `rd_drive` low means the bus is floating. The read-only contents are a fixed function of the address, so no storage or file is needed for that region. A power flag reports standby in two cases: when both selects are released, and when every input has held its value for `IDLE_CYCLES` consecutive clock edges. Any input change brings the part back to active.

The read/write depth is set by `RAM_AW`. The full part uses 15 address bits (32,768 words). The default is 11 so that the default elaboration stays small. Address bits above `RAM_AW` are ignored for the read/write region.

Top module: `dsel_memdev`

## Requirements
- R1: ROM read. With rom select low, ram select high, write strobe high and output strobe low, one edge later `rd_drive`=1 and `rd_data` = addr[7:0] ^ addr[15:8] ^ {6'b0, addr[17:16]}, using all 18 address bits.
- R2: ROM select low, ram select high and write strobe low gives `rd_drive`=0 one edge later, whatever the output strobe is. The write data goes nowhere.
- R3: Ram select low, rom select high and write strobe low stores `wr_data` at the addressed word on that edge, whether the output strobe is high or low. `rd_drive` is 0 after that edge.
- R4: Ram select low, rom select high, write strobe high and output strobe low gives `rd_drive`=1 one edge later, with the word last written at that address. The same selects with the output strobe high give `rd_drive`=0.
- R5: The read/write region decodes only addr[RAM_AW-1:0]. With the default of 11, addresses 0x00805 and 0x00005 reach the same word.
- R6: Both selects high gives `rd_drive`=0 and `pwr_standby`=1 one edge later.
- R7: Both selects low is a conflict. One edge later `sel_conflict`=1 and `rd_drive`=0, no word is written, and the flag clears once the conflict ends.
- R8: After an edge at which any input differs from the previous edge, `pwr_standby`=0 (unless both selects are high). Once all inputs have held for `IDLE_CYCLES` edges (default 1), `pwr_standby`=1, and read data stays driven while in standby.
- R9: During and right after reset: `rd_drive`=0, `rd_data`=0, `sel_conflict`=0 and `pwr_standby`=1.
- R10: Whenever `rd_drive` is 0, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 18 | Shared address bus |
| ram_sel_n | input | 1 | Read/write region select, active low |
| rom_sel_n | input | 1 | Read-only region select, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| wr_data | input | 8 | Data from the bus into the part |
| rd_data | output | 8 | Data the part puts on the bus |
| rd_drive | output | 1 | 1 when the part drives the bus |
| sel_conflict | output | 1 | Both selects were low at the last edge |
| pwr_standby | output | 1 | 1 = standby, 0 = active |

## Verification
The bench reads the ROM at corner addresses (all zero, all one) and at a run of scrambled addresses. Because each ROM word mixes three address slices, this separates a missing or swapped address slice from a correct decode. It writes RAM with the output strobe both high and low and reads back under both strobe levels, so a write that depends on the output strobe, or a read that ignores it, shows up. It then writes and reads at addresses that differ only above the RAM decode width, and attempts a write under conflicting selects, to catch wrong address masking and writes that slip through a conflict. Finally it holds inputs steady and then moves only the address, which separates the idle-driven power flag from the select-driven one.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic [2:0] {
    MD_IDLE     = 3'd0,
    MD_RAM_RD   = 3'd1,
    MD_RAM_WR   = 3'd2,
    MD_ROM_RD   = 3'd3,
    MD_QUIET    = 3'd4,
    MD_CONFLICT = 3'd5
  } dsm_mode_e;

  // Fixed read-only word: three address slices folded by XOR.
  function automatic logic [7:0] rom_word(input logic [17:0] a);
    rom_word = a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]};
  endfunction

endpackage

// File: rtl/dsm_decode.sv
module dsm_decode
  import dsm_pkg::*;
(
  input  logic      ram_sel_n,
  input  logic      rom_sel_n,
  input  logic      wr_n,
  input  logic      oe_n,
  output dsm_mode_e mode,
  output logic      ram_we,
  output logic      conflict
);

  always_comb begin
    mode = MD_IDLE;
    unique case ({ram_sel_n, rom_sel_n})
      2'b00: mode = MD_CONFLICT;
      2'b11: mode = MD_IDLE;
      2'b10: begin
        if (!wr_n)      mode = MD_QUIET;
        else if (!oe_n) mode = MD_ROM_RD;
        else            mode = MD_QUIET;
      end
      default: begin
        if (!wr_n)      mode = MD_RAM_WR;
        else if (!oe_n) mode = MD_RAM_RD;
        else            mode = MD_QUIET;
      end
    endcase
  end

  assign ram_we   = (mode == MD_RAM_WR);
  assign conflict = (mode == MD_CONFLICT);

endmodule

// File: rtl/dsm_ram.sv
module dsm_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dsm_idle_mon.sv
module dsm_idle_mon #(
  parameter int W           = 30,
  parameter int IDLE_CYCLES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  output logic         idle_hit
);

  localparam int CW = $clog2(IDLE_CYCLES + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic [W-1:0]  prev_q;
  logic          prev_vld_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          same;

  assign same = prev_vld_q && (sample == prev_q);

  always_comb begin
    cnt_d = cnt_q;
    if (!same)              cnt_d = '0;
    else if (cnt_q < LIMIT) cnt_d = cnt_q + 1'b1;
  end

  assign idle_hit = (cnt_d >= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      prev_q     <= sample;
      prev_vld_q <= 1'b1;
      cnt_q      <= cnt_d;
    end
  end

endmodule

// File: rtl/dsel_memdev.sv
module dsel_memdev
  import dsm_pkg::*;
#(
  parameter int AW          = 18,
  parameter int DW          = 8,
  parameter int RAM_AW      = 11,
  parameter int IDLE_CYCLES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ram_sel_n,
  input  logic          rom_sel_n,
  input  logic          wr_n,
  input  logic          oe_n,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive,
  output logic          sel_conflict,
  output logic          pwr_standby
);

  localparam int SW = AW + DW + 4;

  dsm_mode_e     mode;
  logic          ram_we, conflict, idle_hit;
  logic [DW-1:0] ram_q, rom_q;
  logic [DW-1:0] data_d;
  logic          drive_d, stby_d;

  dsm_decode u_dec (
    .ram_sel_n (ram_sel_n),
    .rom_sel_n (rom_sel_n),
    .wr_n      (wr_n),
    .oe_n      (oe_n),
    .mode      (mode),
    .ram_we    (ram_we),
    .conflict  (conflict)
  );

  dsm_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (addr[RAM_AW-1:0]),
    .wdata (wr_data),
    .raddr (addr[RAM_AW-1:0]),
    .rdata (ram_q)
  );

  assign rom_q = rom_word(addr);

  dsm_idle_mon #(.W(SW), .IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   ({addr, ram_sel_n, rom_sel_n, wr_n, oe_n, wr_data}),
    .idle_hit (idle_hit)
  );

  always_comb begin
    drive_d = 1'b0;
    data_d  = '0;
    case (mode)
      MD_ROM_RD: begin drive_d = 1'b1; data_d = rom_q; end
      MD_RAM_RD: begin drive_d = 1'b1; data_d = ram_q; end
      default:   ;
    endcase
    stby_d = (mode == MD_IDLE) || idle_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data      <= '0;
      rd_drive     <= 1'b0;
      sel_conflict <= 1'b0;
      pwr_standby  <= 1'b1;
    end else begin
      rd_data      <= data_d;
      rd_drive     <= drive_d;
      sel_conflict <= conflict;
      pwr_standby  <= stby_d;
    end
  end

endmodule

// File: rtl/dsel_memdev_chk.sv
module dsel_memdev_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [17:0] addr,
  input logic        ram_sel_n,
  input logic        rom_sel_n,
  input logic        wr_n,
  input logic        oe_n,
  input logic [7:0]  rd_data,
  input logic        rd_drive,
  input logic        sel_conflict,
  input logic        pwr_standby
);

  assert_rom_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_sel_n && ram_sel_n && wr_n && !oe_n) |=>
      (rd_drive && rd_data == dsm_pkg::rom_word($past(addr))));

  assert_rom_wr_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_sel_n && ram_sel_n && !wr_n) |=> !rd_drive);

  assert_ram_wr_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_sel_n && rom_sel_n && !wr_n) |=> !rd_drive);

  assert_ram_oe_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_sel_n && rom_sel_n && wr_n && oe_n) |=> !rd_drive);

  assert_both_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel_n && rom_sel_n) |=> (pwr_standby && !rd_drive));

  assert_conflict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_sel_n && !rom_sel_n) |=> (sel_conflict && !rd_drive));

  assert_conflict_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_sel_n && !rom_sel_n) |=> !sel_conflict);

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr != $past(addr)) && !(ram_sel_n && rom_sel_n)) |=> !pwr_standby);

  assert_quiet_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> (rd_data == 8'h00));

endmodule

bind dsel_memdev dsel_memdev_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .ram_sel_n    (ram_sel_n),
  .rom_sel_n    (rom_sel_n),
  .wr_n         (wr_n),
  .oe_n         (oe_n),
  .rd_data      (rd_data),
  .rd_drive     (rd_drive),
  .sel_conflict (sel_conflict),
  .pwr_standby  (pwr_standby)
);

// File: tb/dsel_memdev_tb_top.sv
`timescale 1ns/1ps
module dsel_memdev_tb_top;

  localparam int RAM_AW = 11;
  localparam logic [17:0] RMASK = 18'((1 << RAM_AW) - 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic        ram_sel_n = 1'b1, rom_sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        rd_drive, sel_conflict, pwr_standby;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dsel_memdev #(.RAM_AW(RAM_AW), .IDLE_CYCLES(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive),
    .sel_conflict(sel_conflict), .pwr_standby(pwr_standby)
  );

  typedef struct {
    string      tag;
    logic       en;
    logic [7:0] data;
    logic       cfl;
    logic       chk_stby;
    logic       stby;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  model [int];

  function automatic logic [7:0] exp_rom(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]};
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs and push the expected outcome.
  task automatic step(input string tag, input logic [17:0] a, input logic rmn, input logic romn,
                      input logic w, input logic o, input logic [7:0] d,
                      input logic cs, input logic st);
    exp_t e;
    @(negedge clk);
    addr = a; ram_sel_n = rmn; rom_sel_n = romn; wr_n = w; oe_n = o; wr_data = d;
    e.tag = tag; e.en = 1'b0; e.data = 8'h00; e.cfl = 1'b0; e.chk_stby = cs; e.stby = st;
    if (!rmn && !romn) e.cfl = 1'b1;
    else if (!romn && rmn && w && !o) begin e.en = 1'b1; e.data = exp_rom(a); end
    else if (!rmn && romn && w && !o) begin
      e.en = 1'b1;
      e.data = model.exists(int'(a & RMASK)) ? model[int'(a & RMASK)] : 8'h00;
    end
    if (!rmn && romn && !w) model[int'(a & RMASK)] = d;
    sb.push_back(e);
  endtask

  // Monitor: compare after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "drive", int'(rd_drive), int'(e.en));
        check(e.tag, "data", int'(rd_data), int'(e.data));
        check(e.tag, "conflict", int'(sel_conflict), int'(e.cfl));
        if (e.chk_stby) check(e.tag, "standby", int'(pwr_standby), int'(e.stby));
      end
    end
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [17:0] lf;
    repeat (3) @(posedge clk);
    #2;
    check("R9", "drive", int'(rd_drive), 0);
    check("R9", "data", int'(rd_data), 0);
    check("R9", "conflict", int'(sel_conflict), 0);
    check("R9", "standby", int'(pwr_standby), 1);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R9", "standby after release", int'(pwr_standby), 1);

    // R1 ROM reads at corners and scrambled addresses
    step("R1", 18'h00000, 1, 0, 1, 0, 8'h00, 1, 0);
    step("R1", 18'h3FFFF, 1, 0, 1, 0, 8'h00, 1, 0);
    step("R1", 18'h12345, 1, 0, 1, 0, 8'h00, 0, 0);
    step("R1", 18'h2A5A5, 1, 0, 1, 0, 8'h00, 0, 0);
    lf = 18'h1ACE1;
    for (int i = 0; i < 24; i++) begin
      lf = {lf[16:0], lf[17] ^ lf[10]};
      step("R1", lf, 1, 0, 1, 0, 8'h00, 0, 0);
    end
    // R2 ROM with write strobe low, both output strobe levels
    step("R2", 18'h01234, 1, 0, 0, 0, 8'h5A, 0, 0);
    step("R2", 18'h01235, 1, 0, 0, 1, 8'h5A, 0, 0);
    // R3 RAM writes with output strobe high and low
    step("R3", 18'h00010, 0, 1, 0, 1, 8'hA1, 0, 0);
    step("R3", 18'h00011, 0, 1, 0, 0, 8'hB2, 0, 0);
    step("R3", 18'h007FF, 0, 1, 0, 0, 8'hC3, 0, 0);
    for (int i = 0; i < 8; i++)
      step("R3", 18'(32 + i * 37), 0, 1, 0, i[0], 8'(8'h40 + i * 29), 0, 0);
    // R4 RAM reads, and output strobe high floats
    step("R4", 18'h00010, 0, 1, 1, 0, 8'h00, 0, 0);
    step("R4", 18'h00011, 0, 1, 1, 0, 8'h00, 0, 0);
    step("R4", 18'h007FF, 0, 1, 1, 0, 8'h00, 0, 0);
    for (int i = 0; i < 8; i++)
      step("R4", 18'(32 + i * 37), 0, 1, 1, 0, 8'h00, 0, 0);
    step("R4", 18'h00010, 0, 1, 1, 1, 8'h00, 0, 0);
    // R5 aliasing above the RAM decode width
    step("R5", 18'h00805, 0, 1, 0, 1, 8'h77, 0, 0);
    step("R5", 18'h00005, 0, 1, 1, 0, 8'h00, 0, 0);
    step("R5", 18'h3F805, 0, 1, 1, 0, 8'h00, 0, 0);
    // R6 both selects released
    step("R6", 18'h00010, 1, 1, 1, 0, 8'h00, 1, 1);
    step("R6", 18'h00020, 1, 1, 0, 0, 8'h11, 1, 1);
    // R7 conflict: no write, flag set then cleared
    step("R7", 18'h00010, 0, 0, 0, 0, 8'hEE, 0, 0);
    step("R7", 18'h00011, 0, 0, 1, 0, 8'hEE, 0, 0);
    step("R7", 18'h00010, 0, 1, 1, 0, 8'h00, 0, 0);
    // R8 idle standby then wake on address change
    step("R8", 18'h00011, 0, 1, 1, 0, 8'h00, 1, 0);
    step("R8", 18'h00011, 0, 1, 1, 0, 8'h00, 1, 1);
    step("R8", 18'h00011, 0, 1, 1, 0, 8'h00, 1, 1);
    step("R8", 18'h00010, 0, 1, 1, 0, 8'h00, 1, 0);
    step("R8", 18'h0ABCD, 1, 0, 1, 0, 8'h00, 1, 0);
    step("R8", 18'h0ABCD, 1, 0, 1, 0, 8'h00, 1, 1);
    step("R8", 18'h0ABCD, 1, 0, 1, 0, 8'h01, 1, 0);
    // R10 rd_data is zero whenever not driving (covered in every float step above)
    step("R10", 18'h3FFFF, 0, 1, 1, 1, 8'hFF, 0, 0);

    repeat (4) @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule